// File: doc/BRIEF.md
# Parallel Host Mailbox Interface

This block connects a host CPU to the device over an 8-bit parallel port with no glue logic. Each direction has one byte latch. The host writes into the inbound latch and the device drains it. The device fills the outbound latch and the host reads it. Both directions work at the same time. The host sees two status flags, an active-low wait request and a sticky error line.

Host strobes are asynchronous to the device clock. The block brings them into the device clock domain through a two-flop synchronizer. A transfer takes effect on the synchronized release of its strobe. The bidirectional data pins are modelled as separate input, output and output-enable signals. On the device side, each direction has a plain valid/ready byte port. The device side also has a pulse input that clears the error.

Top module: `hpi_mailbox`

## Requirements
- R1: After reset, `hst_obe` = 1, `hst_ibf` = 0, `hst_err` = 0, `hst_wait_n` = 1 and `hst_doe` = 0.
- R2: A selected host write is a pulse on `hst_wr_n` while `hst_cs_n` is low. When it ends with the inbound latch empty, the byte on `hst_din` goes into the latch. `hst_ibf` and `dev_rx_valid` then go to 1, and `dev_rx_data` shows that byte.
- R3: A device handshake (`dev_rx_valid` and `dev_rx_ready` both high at a clock edge) empties the inbound latch. `hst_ibf` then goes to 0.
- R4: A device handshake (`dev_tx_valid` and `dev_tx_ready` both high at a clock edge) loads `dev_tx_data` into the outbound latch. `hst_obe` and `dev_tx_ready` then go to 0, and `hst_dout` shows the byte.
- R5: When a selected host read ends with a byte in the outbound latch, `hst_obe` returns to 1.
- R6: A selected host write that ends while `hst_ibf` = 1 sets `hst_err`. It leaves the held byte on `dev_rx_data` unchanged.
- R7: A selected host read that ends while `hst_obe` = 1 sets `hst_err`. `hst_obe` stays 1.
- R8: Once `hst_err` is set, it stays 1 until the device pulses `dev_err_clr`. After that pulse, it reads 0.
- R9: `hst_doe` is 1 only while `hst_cs_n` and `hst_rd_n` are both low.
- R10: `hst_wait_n` is low in the following cases, and high otherwise:
  - the host holds a selected read while the outbound latch is empty;
  - the host holds a selected read in the cycle just after an outbound load;
  - the host holds a selected write while the inbound latch is full.
- R11: Strobes given while `hst_cs_n` is high change no flag, latch or error.
- R12: A host write and a device load can run in the same interval without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_din | input | 8 | Data from the host pins |
| hst_dout | output | 8 | Data to the host pins |
| hst_doe | output | 1 | Drive enable for the host data pins |
| hst_wait_n | output | 1 | Wait request, active low |
| hst_err | output | 1 | Sticky interface fault |
| hst_obe | output | 1 | Outbound latch empty |
| hst_ibf | output | 1 | Inbound latch full |
| dev_tx_data | input | 8 | Byte the device offers to the host |
| dev_tx_valid | input | 1 | Device byte valid |
| dev_tx_ready | output | 1 | Outbound latch can accept a byte |
| dev_rx_data | output | 8 | Byte from the host |
| dev_rx_valid | output | 1 | Inbound byte present |
| dev_rx_ready | input | 1 | Device takes the inbound byte |
| dev_err_clr | input | 1 | Clears the error flag |

## Verification
The bench starts a host read in the cycle right after a device load. A design without the one-cycle guard would let the host finish the access without a wait request. The bench also writes to a full inbound latch. A design that overwrote the latch would show the new byte on `dev_rx_data` and leave the error low.

Three more cases are covered:
- A read from an empty outbound latch must raise the error and keep the empty flag high.
- Strobes with chip select high must change no flag, latch or error.
- A device load during a host write must leave each direction intact.

A design that cleared the error without the clear pulse, or drove the bus outside a selected read, would fail these checks.

// File: rtl/hpi_mailbox.sv
module hpi_mailbox #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hst_cs_n,
  input  logic         hst_rd_n,
  input  logic         hst_wr_n,
  input  logic [W-1:0] hst_din,
  output logic [W-1:0] hst_dout,
  output logic         hst_doe,
  output logic         hst_wait_n,
  output logic         hst_err,
  output logic         hst_obe,
  output logic         hst_ibf,
  input  logic [W-1:0] dev_tx_data,
  input  logic         dev_tx_valid,
  output logic         dev_tx_ready,
  output logic [W-1:0] dev_rx_data,
  output logic         dev_rx_valid,
  input  logic         dev_rx_ready,
  input  logic         dev_err_clr
);
  logic [SYNC-1:0] cs_sy, rd_sy, wr_sy;
  logic cs_s, rd_s, wr_s, rd_d, wr_d;
  logic rd_act, wr_act, fresh;
  logic [W-1:0] in_q, out_q, wr_hold;

  assign cs_s = cs_sy[SYNC-1];
  assign rd_s = rd_sy[SYNC-1];
  assign wr_s = wr_sy[SYNC-1];

  logic tx_fire, rx_fire, wr_done, rd_done, fault;
  assign tx_fire = dev_tx_valid & hst_obe;
  assign rx_fire = dev_rx_ready & hst_ibf;
  assign wr_done = wr_act & wr_s & ~wr_d;
  assign rd_done = rd_act & rd_s & ~rd_d;
  assign fault   = (wr_done & hst_ibf & ~rx_fire) | (rd_done & hst_obe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= '1;
      rd_sy <= '1;
      wr_sy <= '1;
      rd_d  <= 1'b1;
      wr_d  <= 1'b1;
    end else begin
      cs_sy <= {cs_sy[SYNC-2:0], hst_cs_n};
      rd_sy <= {rd_sy[SYNC-2:0], hst_rd_n};
      wr_sy <= {wr_sy[SYNC-2:0], hst_wr_n};
      rd_d  <= rd_s;
      wr_d  <= wr_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act  <= 1'b0;
      rd_act  <= 1'b0;
      wr_hold <= '0;
    end else begin
      if (!cs_s && !wr_s) begin
        wr_act  <= 1'b1;
        wr_hold <= hst_din;
      end else if (wr_s) begin
        wr_act  <= 1'b0;
      end
      if (!cs_s && !rd_s) rd_act <= 1'b1;
      else if (rd_s)      rd_act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_ibf <= 1'b0;
      in_q    <= '0;
    end else if (wr_done && (!hst_ibf || rx_fire)) begin
      hst_ibf <= 1'b1;
      in_q    <= wr_hold;
    end else if (rx_fire) begin
      hst_ibf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_obe <= 1'b1;
      out_q   <= '0;
      fresh   <= 1'b0;
    end else begin
      fresh <= tx_fire;
      if (tx_fire) begin
        hst_obe <= 1'b0;
        out_q   <= dev_tx_data;
      end else if (rd_done) begin
        hst_obe <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hst_err <= 1'b0;
    else        hst_err <= (hst_err & ~dev_err_clr) | fault;
  end

  assign hst_dout     = out_q;
  assign hst_doe      = ~hst_cs_n & ~hst_rd_n;
  assign hst_wait_n   = ~(~hst_cs_n & ((~hst_rd_n & (hst_obe | fresh)) | (~hst_wr_n & hst_ibf)));
  assign dev_tx_ready = hst_obe;
  assign dev_rx_data  = in_q;
  assign dev_rx_valid = hst_ibf;
endmodule

// File: rtl/hpi_mailbox_chk.sv
module hpi_mailbox_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hst_cs_n,
  input logic         hst_rd_n,
  input logic         hst_wait_n,
  input logic         hst_err,
  input logic         hst_obe,
  input logic         hst_ibf,
  input logic         dev_tx_valid,
  input logic         dev_tx_ready,
  input logic [W-1:0] dev_rx_data,
  input logic         dev_rx_ready,
  input logic         dev_err_clr
);
  a_r4_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && dev_tx_ready |=> !hst_obe);
  a_r4_obe_falls_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hst_obe) |-> $past(dev_tx_valid));
  a_r3_ibf_falls_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hst_ibf) |-> $past(dev_rx_ready));
  a_r6_held_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ibf && !dev_rx_ready |=> $stable(dev_rx_data));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hst_err && !dev_err_clr |=> hst_err);
  a_r10_wait_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && dev_tx_ready |=> (!hst_wait_n || hst_cs_n || hst_rd_n));
endmodule

bind hpi_mailbox hpi_mailbox_chk #(.W(W)) chk_i (.*);

// File: tb/hpi_mailbox_tb_top.sv
module hpi_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0, tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, err_clr = 1'b0;
  logic [7:0] dout, rx_data;
  logic doe, wait_n, err, obe, ibf, tx_ready, rx_valid;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  hpi_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .hst_cs_n(cs_n), .hst_rd_n(rd_n), .hst_wr_n(wr_n),
    .hst_din(din), .hst_dout(dout), .hst_doe(doe), .hst_wait_n(wait_n),
    .hst_err(err), .hst_obe(obe), .hst_ibf(ibf), .dev_tx_data(tx_data),
    .dev_tx_valid(tx_valid), .dev_tx_ready(tx_ready), .dev_rx_data(rx_data),
    .dev_rx_valid(rx_valid), .dev_rx_ready(rx_ready), .dev_err_clr(err_clr));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] b, input logic sel);
    @(negedge clk);
    din = b; cs_n = ~sel; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1; cs_n = 1'b1;
    idle(5);
  endtask

  task automatic host_rd(output logic [7:0] b, input logic sel);
    @(negedge clk);
    cs_n = ~sel; rd_n = 1'b0;
    idle(4);
    b = dout;
    rd_n = 1'b1; cs_n = 1'b1;
    idle(5);
  endtask

  task automatic dev_load(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic dev_take();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(obe == 1 && ibf == 0 && err == 0, "R1 flags", {obe, ibf, err}, 3'b100);
    chk(wait_n == 1 && doe == 0, "R1 wait/doe", {wait_n, doe}, 2'b10);
  endtask

  task automatic t_write_take();
    host_wr(8'hA5, 1'b1);
    chk(ibf && rx_valid, "R2 ibf", ibf, 1);
    chk(rx_data == 8'hA5, "R2 data", rx_data, 8'hA5);
    dev_take();
    chk(!ibf && !rx_valid, "R3 ibf cleared", ibf, 0);
  endtask

  task automatic t_load_read();
    logic [7:0] got;
    dev_load(8'h3C);
    chk(!obe && !tx_ready, "R4 obe low", obe, 0);
    chk(dout == 8'h3C, "R4 dout", dout, 8'h3C);
    host_rd(got, 1'b1);
    chk(got == 8'h3C, "R5 read byte", got, 8'h3C);
    chk(obe && !err, "R5 obe back", {obe, err}, 2'b10);
  endtask

  task automatic t_overrun();
    host_wr(8'h11, 1'b1);
    host_wr(8'h22, 1'b1);
    chk(err == 1, "R6 err", err, 1);
    chk(rx_data == 8'h11, "R6 held byte", rx_data, 8'h11);
    idle(3);
    chk(err == 1, "R8 sticky", err, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(err == 0, "R8 cleared", err, 0);
    dev_take();
  endtask

  task automatic t_underrun();
    logic [7:0] got;
    host_rd(got, 1'b1);
    chk(err == 1 && obe == 1, "R7 read empty", {err, obe}, 2'b11);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_doe_wait();
    @(negedge clk);
    rd_n = 1'b0;
    #1 chk(doe == 0, "R9 doe unselected", doe, 0);
    cs_n = 1'b0;
    #1 chk(doe == 1, "R9 doe selected", doe, 1);
    chk(wait_n == 0, "R10 wait on empty", wait_n, 0);
    rd_n = 1'b1; cs_n = 1'b1;
    #1 chk(doe == 0 && wait_n == 1, "R9 doe released", {doe, wait_n}, 2'b01);
    idle(6);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    dev_load(8'h77);
    cs_n = 1'b0; rd_n = 1'b0;
    #1 chk(wait_n == 0, "R10 wait just after load", wait_n, 0);
    @(negedge clk);
    chk(wait_n == 1, "R10 wait released", wait_n, 1);
    idle(3);
    rd_n = 1'b1; cs_n = 1'b1;
    idle(5);
    chk(obe == 1 && err == 0, "R5 read after wait", {obe, err}, 2'b10);
    host_wr(8'h55, 1'b1);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    #1 chk(wait_n == 0, "R10 wait on full", wait_n, 0);
    wr_n = 1'b1; cs_n = 1'b1;
    idle(5);
    dev_take();
  endtask

  task automatic t_unselected();
    logic [7:0] got;
    host_wr(8'h99, 1'b0);
    chk(!ibf && !err, "R11 write ignored", {ibf, err}, 0);
    dev_load(8'h42);
    host_rd(got, 1'b0);
    chk(!obe && !err, "R11 read ignored", {obe, err}, 0);
    host_rd(got, 1'b1);
  endtask

  task automatic t_duplex();
    logic [7:0] got;
    @(negedge clk);
    din = 8'hC3; cs_n = 1'b0; wr_n = 1'b0;
    tx_data = 8'h5A; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    idle(3);
    wr_n = 1'b1; cs_n = 1'b1;
    idle(5);
    chk(ibf && rx_data == 8'hC3, "R12 inbound", rx_data, 8'hC3);
    chk(!obe && dout == 8'h5A, "R12 outbound", dout, 8'h5A);
    host_rd(got, 1'b1);
    dev_take();
    chk(got == 8'h5A && obe && !ibf && !err, "R12 both drained", got, 8'h5A);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_write_take();
    t_load_read();
    t_overrun();
    t_underrun();
    t_doe_wait();
    t_unselected();
    t_duplex();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule